// File: doc/BRIEF.md
# Multi-Port Scan Chain Router

This block sits between a backplane test port and three local scan ports. It decides which serial path lies between the backplane data input and the backplane data output. The bridge's own register is always in that path. Each local ring that has been released from parking is spliced in after it, in ascending port order. Every spliced ring is closed by a one-bit pad stage. The pad samples the ring's returning data on the falling edge of the backplane clock and passes it on to the next spliced port, or to the backplane output.

The router also fans the backplane clock out to every local port. It forwards the backplane mode-select to released ports and holds a parked port's mode-select at a fixed level, so that its TAP rests in a stable state. It follows the backplane TAP state so that it enables the backplane data output only while data or instructions are being shifted. One active-low enable input switches all local port drivers off together, so that another master can reach the local rings. Address matching and the command decoding that decides which ports to release sit outside the block. They present the chosen park state through a load strobe.

Top module: `scan_chain_router`

## Requirements
- R1: A reset (active-low, sampled on the rising clock edge) parks every port, sets every local mode-select output to 1 and clears the backplane data-output enable.
- R2: Every local clock output equals the backplane clock at all times.
- R3: Every local enable output equals the inverse of `oe_n`, and all ports switch together.
- R4: A released port's mode-select output follows the backplane mode-select input.
- R5: A parked port's mode-select output is held constant. It is 1 if the port has not been released since reset, and 0 once the port has been parked again after being released.
- R6: With every port parked, the backplane data output equals the bridge register's serial output `br_so`.
- R7: Released ports are chained in ascending index order. The lowest released port's data output carries `br_so`. Each released port's returning data is captured into its pad on the falling clock edge. That pad drives the data output of the next higher released port, or the backplane data output if no higher port is released.
- R8: A parked port's data output is driven to 1, and its returning data has no effect on any other output.
- R9: The backplane data-output enable is updated only on the falling clock edge. It is 1 exactly when the tracked TAP state is Shift-DR or Shift-IR.
- R10: When `cfg_load` is 1 at a rising edge, the park state is loaded from `cfg_unpark`, where bit i = 1 releases port i and bit i = 0 parks it. Otherwise the park state is held.
- R11: The TAP tracker follows the standard 16-state sequence on the backplane mode-select. Five consecutive rising edges with mode-select 1 bring it to Test-Logic-Reset from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_b | input | 1 | Backplane test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms_b | input | 1 | Backplane mode-select |
| br_so | input | 1 | Serial output of the bridge's current register (changes on falling edge) |
| oe_n | input | 1 | Active-low enable for all local port drivers |
| cfg_load | input | 1 | Strobe that loads the park state |
| cfg_unpark | input | NPORT | Park state to load; 1 releases the port |
| loc_tdi | input | NPORT | Returning data from each local ring |
| loc_tck | output | NPORT | Local clock outputs |
| loc_tms | output | NPORT | Local mode-select outputs |
| loc_tdo | output | NPORT | Data driven into each local ring |
| loc_en | output | NPORT | Driver enable for each local port |
| bp_tdo | output | 1 | Backplane data output |
| bp_tdo_en | output | 1 | Backplane data-output driver enable |

## Verification
The assertions check, on every cycle, several behaviours that hold in any state. The output enable agrees with the shift states. A load strobe is reflected in the park state one edge later. A parked port's mode-select does not move. Five high mode-select edges always reach Test-Logic-Reset. Reset leaves every port parked. The splicing order, the one-bit delay of each pad, and the difference between a port parked straight from reset and one parked after release can only be shown by the bench's scenarios. These scenarios walk the TAP into both shift states under several park patterns. The bench compares every output with its behavioural model on every clock.

// File: rtl/scan_router_pkg.sv
// Shared types for the scan chain router.
// Assumes: one backplane clock domain; all users import this package.
package scan_router_pkg;

    // Number of local scan ports served by one router.
    localparam int unsigned LOCAL_PORTS = 3;

    // TAP controller states as tracked from the backplane mode-select.
    typedef enum logic [3:0] {
        TS_RESET    = 4'd0,
        TS_IDLE     = 4'd1,
        TS_DR_SEL   = 4'd2,
        TS_DR_CAP   = 4'd3,
        TS_DR_SHIFT = 4'd4,
        TS_DR_EX1   = 4'd5,
        TS_DR_PAUSE = 4'd6,
        TS_DR_EX2   = 4'd7,
        TS_DR_UPD   = 4'd8,
        TS_IR_SEL   = 4'd9,
        TS_IR_CAP   = 4'd10,
        TS_IR_SHIFT = 4'd11,
        TS_IR_EX1   = 4'd12,
        TS_IR_PAUSE = 4'd13,
        TS_IR_EX2   = 4'd14,
        TS_IR_UPD   = 4'd15
    } tap_state_e;

endpackage

// File: rtl/srt_tap_tracker.sv
// TAP state tracker.
// Follows the standard 16-state TAP sequence on the backplane mode-select
// and flags the two shift states.
// Assumes: mode-select is stable around the rising clock edge.
module srt_tap_tracker
    import scan_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       shifting
);

    tap_state_e nxt;

    // Next-state selection for the TAP sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   nxt = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   nxt = tms ? TS_DR_EX1   : TS_DR_SHIFT;
            TS_DR_SHIFT: nxt = tms ? TS_DR_EX1   : TS_DR_SHIFT;
            TS_DR_EX1:   nxt = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: nxt = tms ? TS_DR_EX2   : TS_DR_PAUSE;
            TS_DR_EX2:   nxt = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   nxt = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   nxt = tms ? TS_IR_EX1   : TS_IR_SHIFT;
            TS_IR_SHIFT: nxt = tms ? TS_IR_EX1   : TS_IR_SHIFT;
            TS_IR_EX1:   nxt = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: nxt = tms ? TS_IR_EX2   : TS_IR_PAUSE;
            TS_IR_EX2:   nxt = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    // State register, reset to Test-Logic-Reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_RESET;
        else        state <= nxt;
    end

    // Shift flag for the output-enable stage.
    always_comb shifting = (state == TS_DR_SHIFT) || (state == TS_IR_SHIFT);

    // R11
    five_high_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state == TS_RESET));

endmodule

// File: rtl/srt_park_ctrl.sv
// Park-state register and mode-select fan-out.
// Holds which local ports are released, remembers the level at which each
// parked port's mode-select is held, and drives the local mode-select pins.
// Assumes: cfg_load / cfg_unpark come from the bridge's command logic and
// are stable around the rising clock edge.
module srt_park_ctrl #(
    parameter int unsigned NPORT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             cfg_load,
    input  logic [NPORT-1:0] cfg_unpark,
    output logic [NPORT-1:0] unparked,
    output logic [NPORT-1:0] loc_tms
);

    logic [NPORT-1:0] hold_lvl;

    // Park-state register: every port parked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        unparked <= '0;
        else if (cfg_load) unparked <= cfg_unpark;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        // Hold level: 1 after reset (rest in Test-Logic-Reset), 0 once parked from released (rest in Idle).
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_lvl[i] <= 1'b1;
            else if (cfg_load && unparked[i] && !cfg_unpark[i])
                hold_lvl[i] <= 1'b0;
        end

        // Mode-select pin: live for released ports, held level for parked ones.
        always_comb loc_tms[i] = unparked[i] ? tms : hold_lvl[i];

        // R5
        parked_tms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!unparked[i] && $past(!unparked[i])) |-> $stable(loc_tms[i]));
    end

    // R10
    park_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (unparked == $past(cfg_unpark)));

    // R1
    reset_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (unparked == '0));

endmodule

// File: rtl/srt_chain_mux.sv
// Serial chain splicing.
// Captures each port's returning data in a falling-edge pad, then walks the
// ports in ascending order to route the bridge output through every
// released ring and on to the backplane output. Also times the backplane
// output enable to the falling edge.
// Assumes: br_so changes only on the falling clock edge.
module srt_chain_mux #(
    parameter int unsigned NPORT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_so,
    input  logic             shifting,
    input  logic [NPORT-1:0] unparked,
    input  logic [NPORT-1:0] loc_tdi,
    output logic [NPORT-1:0] loc_tdo,
    output logic             bp_tdo,
    output logic             bp_tdo_en
);

    logic [NPORT-1:0] pad;
    logic [NPORT:0]   link;

    // Entry of the walk: the bridge register's serial output.
    always_comb link[0] = br_so;

    for (genvar i = 0; i < NPORT; i++) begin : g_stage
        // Pad stage: resynchronise returning data on the falling edge.
        always_ff @(negedge clk) begin
            if (!rst_n) pad[i] <= 1'b0;
            else        pad[i] <= loc_tdi[i];
        end

        // Port output: carries the chain when released, idles high when parked.
        always_comb loc_tdo[i] = unparked[i] ? link[i] : 1'b1;

        // Chain continues from the pad when released, bypasses the port when parked.
        always_comb link[i+1] = unparked[i] ? pad[i] : link[i];
    end

    // Backplane output: end of the walk.
    always_comb bp_tdo = link[NPORT];

    // Output enable: follows the shift states, updated on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) bp_tdo_en <= 1'b0;
        else        bp_tdo_en <= shifting;
    end

    // R9
    tdo_en_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bp_tdo_en == shifting);

endmodule

// File: rtl/scan_chain_router.sv
// Scan chain router top.
// Joins a backplane test port to NPORT local scan ports: clock fan-out,
// mode-select forwarding, driver enables and serial chain splicing.
// Assumes: a single backplane clock; the bridge register and its command
// decoding sit outside and present br_so and the park-state load.
module scan_chain_router
    import scan_router_pkg::*;
#(
    parameter int unsigned NPORT = LOCAL_PORTS
) (
    input  logic             tck_b,
    input  logic             rst_n,
    input  logic             tms_b,
    input  logic             br_so,
    input  logic             oe_n,
    input  logic             cfg_load,
    input  logic [NPORT-1:0] cfg_unpark,
    input  logic [NPORT-1:0] loc_tdi,
    output logic [NPORT-1:0] loc_tck,
    output logic [NPORT-1:0] loc_tms,
    output logic [NPORT-1:0] loc_tdo,
    output logic [NPORT-1:0] loc_en,
    output logic             bp_tdo,
    output logic             bp_tdo_en
);

    tap_state_e       tap_state;
    logic             shifting;
    logic [NPORT-1:0] unparked;

    srt_tap_tracker u_tap (
        .clk      (tck_b),
        .rst_n    (rst_n),
        .tms      (tms_b),
        .state    (tap_state),
        .shifting (shifting)
    );

    srt_park_ctrl #(.NPORT(NPORT)) u_park (
        .clk        (tck_b),
        .rst_n      (rst_n),
        .tms        (tms_b),
        .cfg_load   (cfg_load),
        .cfg_unpark (cfg_unpark),
        .unparked   (unparked),
        .loc_tms    (loc_tms)
    );

    srt_chain_mux #(.NPORT(NPORT)) u_chain (
        .clk       (tck_b),
        .rst_n     (rst_n),
        .br_so     (br_so),
        .shifting  (shifting),
        .unparked  (unparked),
        .loc_tdi   (loc_tdi),
        .loc_tdo   (loc_tdo),
        .bp_tdo    (bp_tdo),
        .bp_tdo_en (bp_tdo_en)
    );

    // Clock and driver-enable fan-out, shared by every port.
    for (genvar i = 0; i < NPORT; i++) begin : g_fan
        always_comb loc_tck[i] = tck_b;
        always_comb loc_en[i]  = ~oe_n;
    end

endmodule

// File: tb/scan_chain_router_bench.sv
module scan_chain_router_bench;
    localparam int NP = 3;

    logic          tck_b = 1'b0;
    logic          rst_n = 1'b0;
    logic          tms_b = 1'b1;
    logic          br_so = 1'b0;
    logic          oe_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [NP-1:0] cfg_unpark = '0;
    logic [NP-1:0] loc_tdi = '0;
    logic [NP-1:0] loc_tck, loc_tms, loc_tdo, loc_en;
    logic          bp_tdo, bp_tdo_en;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 tck_b = ~tck_b;

    scan_chain_router #(.NPORT(NP)) u_scan_chain_router (
        .tck_b(tck_b), .rst_n(rst_n), .tms_b(tms_b), .br_so(br_so), .oe_n(oe_n),
        .cfg_load(cfg_load), .cfg_unpark(cfg_unpark), .loc_tdi(loc_tdi),
        .loc_tck(loc_tck), .loc_tms(loc_tms), .loc_tdo(loc_tdo), .loc_en(loc_en),
        .bp_tdo(bp_tdo), .bp_tdo_en(bp_tdo_en)
    );

    // Behavioural model: TAP as two next-state tables (0 reset, 1 idle, 4 shift-DR, 11 shift-IR).
    int nx0 [16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
    int nx1 [16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};
    int        m_st = 0;
    bit [NP-1:0] m_unp = '0;
    bit [NP-1:0] m_lvl = '1;
    bit [NP-1:0] m_pad = '0;
    bit        m_en = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Falling-edge part of the model: pads and output enable.
    task automatic model_neg();
        if (!rst_n) begin
            m_pad = '0; m_en = 0;
        end else begin
            m_pad = loc_tdi;
            m_en = (m_st == 4) || (m_st == 11);
        end
    endtask

    // Rising-edge part of the model: TAP, park state, hold levels.
    task automatic model_pos();
        if (!rst_n) begin
            m_st = 0; m_unp = '0; m_lvl = '1;
        end else begin
            m_st = tms_b ? nx1[m_st] : nx0[m_st];
            if (cfg_load) begin
                for (int k = 0; k < NP; k++)
                    if (m_unp[k] && !cfg_unpark[k]) m_lvl[k] = 0;
                m_unp = cfg_unpark;
            end
        end
    endtask

    task automatic compare();
        bit [NP-1:0] e_tdo, e_tms;
        bit l;
        l = br_so;
        for (int k = 0; k < NP; k++) begin
            if (m_unp[k]) begin
                e_tdo[k] = l; l = m_pad[k]; e_tms[k] = tms_b;
            end else begin
                e_tdo[k] = 1'b1; e_tms[k] = m_lvl[k];
            end
        end
        chk("R4 R5 loc_tms", loc_tms, e_tms);
        chk("R7 R8 loc_tdo", loc_tdo, e_tdo);
        chk("R6 R7 bp_tdo", bp_tdo, l);
        chk("R9 R11 bp_tdo_en", bp_tdo_en, m_en);
        chk("R3 loc_en", loc_en, oe_n ? 0 : 7);
        chk("R2 loc_tck high", loc_tck, 7);
    endtask

    task automatic step(input bit rst, input bit t, input bit ld, input bit [NP-1:0] up, input bit oen);
        @(negedge tck_b);
        model_neg();
        #1;
        chk("R2 loc_tck low", loc_tck, 0);
        rst_n = rst; tms_b = t; cfg_load = ld; cfg_unpark = up; oe_n = oen;
        br_so = 1'($urandom);
        loc_tdi = 3'($urandom);
        @(posedge tck_b);
        model_pos();
        #1;
        compare();
    endtask

    // Walk from Run-Test/Idle into Shift-DR (tms 1,0,0).
    task automatic to_shift_dr(input bit [NP-1:0] up);
        step(1, 1, 0, up, 0);
        step(1, 0, 0, up, 0);
        step(1, 0, 0, up, 0);
    endtask

    initial begin
        // R1: reset phase
        for (int i = 0; i < 3; i++) step(0, 1, 0, '0, 0);
        step(1, 1, 0, '0, 0);
        chk("R1 loc_tms after reset", loc_tms, 7);
        chk("R1 bp_tdo_en after reset", bp_tdo_en, 0);
        chk("R1 loc_tdo parked after reset", loc_tdo, 7);

        // R6: all parked, Shift-DR
        step(1, 0, 0, '0, 0);
        to_shift_dr('0);
        for (int i = 0; i < 8; i++) step(1, 0, 0, '0, 0);
        chk("R9 en in Shift-DR", bp_tdo_en, 1);

        // R10 R7: release port 1 only, then shift
        step(1, 1, 1, 3'b010, 0);
        step(1, 1, 0, 3'b010, 0);
        step(1, 0, 0, 3'b010, 0);
        to_shift_dr(3'b010);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 3'b010, 0);

        // R7: ports 0 and 2, then all three
        step(1, 0, 1, 3'b101, 0);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 3'b101, 0);
        step(1, 0, 1, 3'b111, 0);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 3'b111, 0);

        // R5: park everything after release -> hold level 0
        step(1, 1, 1, 3'b000, 0);
        step(1, 1, 0, 3'b000, 0);
        chk("R5 parked-after-release tms held low", loc_tms, 0);

        // R11: five high edges reach reset, enable drops
        for (int i = 0; i < 5; i++) step(1, 1, 0, '0, 0);
        step(1, 1, 0, '0, 0);
        chk("R11 en low in reset", bp_tdo_en, 0);

        // Shift-IR with port 2 released
        step(1, 0, 1, 3'b100, 0);
        step(1, 1, 0, 3'b100, 0);
        step(1, 1, 0, 3'b100, 0);
        step(1, 0, 0, 3'b100, 0);
        step(1, 0, 0, 3'b100, 0);
        step(1, 0, 0, 3'b100, 0);
        chk("R9 en in Shift-IR", bp_tdo_en, 1);
        for (int i = 0; i < 8; i++) step(1, 0, 0, 3'b100, 0);

        // R3: drivers off together
        for (int i = 0; i < 4; i++) step(1, 0, 0, 3'b100, 1);
        chk("R3 all drivers off", loc_en, 0);

        // Random mix
        for (int i = 0; i < 400; i++)
            step(1, ($urandom % 3) == 0, ($urandom % 8) == 0, 3'($urandom), ($urandom % 6) == 0);

        // R1: reset again restores hold level 1
        step(0, 1, 0, '0, 0);
        step(0, 1, 0, '0, 0);
        step(1, 1, 0, '0, 0);
        chk("R1 loc_tms after second reset", loc_tms, 7);
        chk("R1 en after second reset", bp_tdo_en, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule